// File: doc/BRIEF.md
# Page Access Rights and Key Checker

This block sits directly after a page-table walk. The walker supplies several inputs:

- the combined user, writable and no-execute rights gathered along the walk;
- the final leaf entry;
- a walk status (clean, absent entry, or reserved-bit violation).

The requester supplies the access type (read, write or fetch) and the privilege level. Control flags complete the picture: write protection, supervisor execute guard, supervisor access guard, long mode, no-execute enable, extended addressing, and the two protection-key enables.

From these the block produces four results:

- a grant or deny decision;
- the read/write/execute permission set that a translation cache may keep;
- a write-back request carrying the leaf entry with its accessed and dirty flags updated;
- a page-fault error code.

Protection keys are taken from the leaf entry. Each key indexes a pair of rights bits in one of two key-rights registers. The page's ownership (user or supervisor) selects which register applies.

Each request is a one-cycle strobe. All results are registered and appear together one cycle later, marked by a one-cycle valid pulse. Walking the tables and delivering the exception belong to neighbouring blocks.

Top module: `pgchk_top`

## Requirements
- R1: `out_valid` pulses high exactly in the cycle after `req_valid` is high and is low otherwise. After reset every output is zero.
- R2: A user-mode access (`user_mode`=1) to a page whose combined user right is clear is denied with a protection fault.
- R3: Read permission is withheld only when a supervisor access carries the access guard (`sup_access_guard`=1) and the page is a user page.
- R4: Write permission requires read permission plus either the writable right, or a supervisor access with write protection off (`wp_en`=0).
- R5: Execute permission requires the combined no-execute flag to be clear. For supervisor accesses it also requires that the execute guard is off or the page is not a user page.
- R6: Key rights apply only in long mode. User pages use `ukey_rights` when `ukey_en`=1, and supervisor pages use `skey_rights` when `skey_en`=1. Otherwise keys restrict nothing.
- R7: The key k is leaf bits 62:59. Rights bit 2k removes read and write. Rights bit 2k+1 removes write only when the access is user mode or `wp_en`=1. Keys never remove execute.
- R8: An access denied by its key rights sets error bit 5 (key) and bit 0 (protection).
- R9: On a grant, the new entry sets leaf bit 5 (accessed), and also bit 6 (dirty) for a write. `wb_req` is raised only if the entry changed.
- R10: If the granted entry is still clean (bit 6 clear), write permission is removed from `perm`. On a deny, `perm` is 0 and no write-back is requested.
- R11: Error code bits are: 0 protection, 1 write, 2 user, 3 reserved, 4 fetch, 5 key. A reserved-bit walk status sets bits 3 and 0. An absent entry leaves bit 0 clear. The code is 0 on a grant.
- R12: Error bit 4 is set for a denied fetch only when `nx_en` and `pae_en` are both set, or `sup_exec_guard` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| walk_status | input | 2 | 0 clean walk, 1 absent entry, 2 reserved-bit violation |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| user_mode | input | 1 | Access made at user privilege |
| eff_user | input | 1 | Combined user right of the walk |
| eff_write | input | 1 | Combined writable right of the walk |
| eff_noexec | input | 1 | Combined no-execute flag of the walk |
| leaf | input | 64 | Leaf entry (bit 5 accessed, bit 6 dirty, bits 62:59 key) |
| wp_en | input | 1 | Supervisor write protection |
| sup_exec_guard | input | 1 | Supervisor execute prevention on user pages |
| sup_access_guard | input | 1 | Access made in supervisor access-prevention context |
| long_mode | input | 1 | Long mode active |
| nx_en | input | 1 | No-execute feature enabled |
| pae_en | input | 1 | Extended physical addressing enabled |
| ukey_en | input | 1 | Enable keys for user pages |
| skey_en | input | 1 | Enable keys for supervisor pages |
| ukey_rights | input | 32 | Key rights for user pages, two bits per key |
| skey_rights | input | 32 | Key rights for supervisor pages, two bits per key |
| out_valid | output | 1 | Results valid |
| allow | output | 1 | Access granted |
| perm | output | 3 | Permission set: bit 0 read, bit 1 write, bit 2 execute |
| wb_req | output | 1 | Leaf write-back needed |
| wb_entry | output | 64 | Updated leaf entry |
| err_code | output | 6 | Page-fault error code |

## Verification
Every result (decision, permission set, write-back and error code) is registered from the strobe cycle. All of them are therefore due one clock edge after `req_valid` is seen, together with the `out_valid` pulse.

The bench drives each request on a falling edge and holds the strobe for one cycle. It then samples all outputs on the next falling edge, which falls midway between the registering edge and the following one.

One further falling edge later, it confirms that `out_valid` has dropped again.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        WALK_OK     = 2'd0,
        WALK_ABSENT = 2'd1,
        WALK_RSVD   = 2'd2
    } walk_e;

    // permission set: bit0 read, bit1 write, bit2 execute
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam int ERR_W     = 6;
    localparam int ERR_PROT  = 0;
    localparam int ERR_WRITE = 1;
    localparam int ERR_USER  = 2;
    localparam int ERR_RSVD  = 3;
    localparam int ERR_FETCH = 4;
    localparam int ERR_KEY   = 5;

    localparam perm_t PERM_ALL  = '{x: 1'b1, w: 1'b1, r: 1'b1};
    localparam perm_t PERM_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};

    typedef struct packed {
        logic             allow;
        perm_t            perm;
        logic             wb_req;
        logic [ERR_W-1:0] err;
    } verdict_t;

    // permission bit that a given access type needs
    function automatic perm_t need_of(input logic [1:0] acc);
        perm_t n;
        n = PERM_NONE;
        case (acc)
            ACC_READ:  n.r = 1'b1;
            ACC_WRITE: n.w = 1'b1;
            ACC_FETCH: n.x = 1'b1;
            default:   n = PERM_NONE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pgchk_rights.sv
module pgchk_rights
    import pgchk_pkg::*;
(
    input  logic  user_mode,
    input  logic  eff_user,
    input  logic  eff_write,
    input  logic  eff_noexec,
    input  logic  wp_en,
    input  logic  sup_exec_guard,
    input  logic  sup_access_guard,
    output perm_t base
);
    logic rd_ok;
    logic wr_ok;
    logic ex_ok;

    always_comb begin
        // supervisor in guarded context may not touch user pages
        rd_ok = !(!user_mode && sup_access_guard && eff_user);
        // writable page, or supervisor with write protection off
        wr_ok = rd_ok && (eff_write || (!user_mode && !wp_en));
        // supervisor may not run user code under the execute guard
        ex_ok = !eff_noexec && (user_mode || !(sup_exec_guard && eff_user));
        base  = '{x: ex_ok, w: wr_ok, r: rd_ok};
    end

endmodule

// File: rtl/pgchk_keys.sv
module pgchk_keys
    import pgchk_pkg::*;
#(
    parameter int ENTRY_W = 64,
    parameter int KEY_W   = 4,
    parameter int KEY_LSB = 59,
    localparam int NKEYS  = 1 << KEY_W,
    localparam int RIGHTS_W = 2 * NKEYS
) (
    input  logic [ENTRY_W-1:0]  leaf,
    input  logic                user_mode,
    input  logic                eff_user,
    input  logic                wp_en,
    input  logic                long_mode,
    input  logic                ukey_en,
    input  logic                skey_en,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output perm_t               key_perm
);
    logic [KEY_W-1:0]    key;
    logic                active;
    logic [RIGHTS_W-1:0] rights;
    logic [1:0]          pair [NKEYS];
    logic [1:0]          sel;

    assign key = leaf[KEY_LSB +: KEY_W];

    always_comb begin
        if (!long_mode) begin
            active = 1'b0;
        end else if (eff_user) begin
            active = ukey_en;
        end else begin
            active = skey_en;
        end
        rights = eff_user ? ukey_rights : skey_rights;
    end

    // split the rights register into one pair per key
    for (genvar g = 0; g < NKEYS; g++) begin : g_pair
        assign pair[g] = rights[2*g +: 2];
    end

    assign sel = pair[key];

    always_comb begin
        key_perm = PERM_ALL;
        if (active) begin
            if (sel[0]) begin
                key_perm.r = 1'b0;
                key_perm.w = 1'b0;
            end else if (sel[1] && (user_mode || wp_en)) begin
                key_perm.w = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pgchk_status.sv
module pgchk_status #(
    parameter int ENTRY_W   = 64,
    parameter int ACC_BIT   = 5,
    parameter int DIRTY_BIT = 6
) (
    input  logic [ENTRY_W-1:0] leaf,
    input  logic               is_write,
    output logic [ENTRY_W-1:0] new_entry,
    output logic               changed,
    output logic               clean
);
    always_comb begin
        new_entry          = leaf;
        new_entry[ACC_BIT] = 1'b1;
        if (is_write) begin
            new_entry[DIRTY_BIT] = 1'b1;
        end
        changed = (new_entry != leaf);
        clean   = !new_entry[DIRTY_BIT];
    end

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int ENTRY_W   = 64,
    parameter int KEY_W     = 4,
    parameter int KEY_LSB   = 59,
    parameter int ACC_BIT   = 5,
    parameter int DIRTY_BIT = 6,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          walk_status,
    input  logic [1:0]          acc_type,
    input  logic                user_mode,
    input  logic                eff_user,
    input  logic                eff_write,
    input  logic                eff_noexec,
    input  logic [ENTRY_W-1:0]  leaf,
    input  logic                wp_en,
    input  logic                sup_exec_guard,
    input  logic                sup_access_guard,
    input  logic                long_mode,
    input  logic                nx_en,
    input  logic                pae_en,
    input  logic                ukey_en,
    input  logic                skey_en,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output logic                out_valid,
    output logic                allow,
    output logic [2:0]          perm,
    output logic                wb_req,
    output logic [ENTRY_W-1:0]  wb_entry,
    output logic [ERR_W-1:0]    err_code
);
    perm_t              base;
    perm_t              key_perm;
    perm_t              combined;
    perm_t              need;
    logic [ENTRY_W-1:0] new_entry;
    logic               changed;
    logic               clean;
    logic               is_write;
    verdict_t           vd;

    assign is_write = (acc_type == ACC_WRITE);
    assign need     = need_of(acc_type);

    pgchk_rights u_rights (
        .user_mode        (user_mode),
        .eff_user         (eff_user),
        .eff_write        (eff_write),
        .eff_noexec       (eff_noexec),
        .wp_en            (wp_en),
        .sup_exec_guard   (sup_exec_guard),
        .sup_access_guard (sup_access_guard),
        .base             (base)
    );

    pgchk_keys #(
        .ENTRY_W (ENTRY_W),
        .KEY_W   (KEY_W),
        .KEY_LSB (KEY_LSB)
    ) u_keys (
        .leaf        (leaf),
        .user_mode   (user_mode),
        .eff_user    (eff_user),
        .wp_en       (wp_en),
        .long_mode   (long_mode),
        .ukey_en     (ukey_en),
        .skey_en     (skey_en),
        .ukey_rights (ukey_rights),
        .skey_rights (skey_rights),
        .key_perm    (key_perm)
    );

    pgchk_status #(
        .ENTRY_W   (ENTRY_W),
        .ACC_BIT   (ACC_BIT),
        .DIRTY_BIT (DIRTY_BIT)
    ) u_status (
        .leaf      (leaf),
        .is_write  (is_write),
        .new_entry (new_entry),
        .changed   (changed),
        .clean     (clean)
    );

    assign combined = base & key_perm;

    always_comb begin
        logic walk_ok;
        logic user_deny;
        logic key_deny;
        logic perm_deny;
        logic prot;
        logic fetch_tag;

        walk_ok   = (walk_status == WALK_OK);
        user_deny = user_mode && !eff_user;
        key_deny  = !user_deny && ((key_perm & need) == PERM_NONE);
        perm_deny = (combined & need) == PERM_NONE;
        prot      = walk_ok && (user_deny || key_deny || perm_deny);
        fetch_tag = (acc_type == ACC_FETCH) && ((nx_en && pae_en) || sup_exec_guard);

        vd = '0;
        if (walk_ok && !prot) begin
            vd.allow  = 1'b1;
            vd.perm   = combined;
            vd.wb_req = changed;
            if (clean) begin
                vd.perm.w = 1'b0;
            end
        end else begin
            vd.err[ERR_PROT]  = prot || (walk_status == WALK_RSVD);
            vd.err[ERR_RSVD]  = (walk_status == WALK_RSVD);
            vd.err[ERR_KEY]   = walk_ok && key_deny;
            vd.err[ERR_WRITE] = is_write;
            vd.err[ERR_USER]  = user_mode;
            vd.err[ERR_FETCH] = fetch_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            allow     <= 1'b0;
            perm      <= '0;
            wb_req    <= 1'b0;
            wb_entry  <= '0;
            err_code  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                allow    <= vd.allow;
                perm     <= vd.perm;
                wb_req   <= vd.wb_req;
                wb_entry <= new_entry;
                err_code <= vd.err;
            end
        end
    end

endmodule

// File: rtl/pgchk_checker.sv
module pgchk_checker
    import pgchk_pkg::*;
#(
    parameter int ENTRY_W = 64,
    parameter int ACC_BIT = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [1:0]         acc_type,
    input logic               out_valid,
    input logic               allow,
    input logic [2:0]         perm,
    input logic               wb_req,
    input logic [ENTRY_W-1:0] wb_entry,
    input logic [ERR_W-1:0]   err_code
);
    assert_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_deny_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !allow) |-> (perm == 3'b000 && !wb_req));

    assert_grant_needs_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && allow) |-> ((perm & need_of($past(acc_type))) != 3'b000));

    assert_grant_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && allow) |-> (err_code == '0));

    assert_rsvd_prot_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && err_code[ERR_RSVD]) |-> err_code[ERR_PROT]);

    assert_key_prot_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && err_code[ERR_KEY]) |-> err_code[ERR_PROT]);

    assert_wb_marked_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && wb_req) |-> (allow && wb_entry[ACC_BIT]));

endmodule

bind pgchk_top pgchk_checker #(
    .ENTRY_W (ENTRY_W),
    .ACC_BIT (ACC_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .acc_type  (acc_type),
    .out_valid (out_valid),
    .allow     (allow),
    .perm      (perm),
    .wb_req    (wb_req),
    .wb_entry  (wb_entry),
    .err_code  (err_code)
);

// File: tb/tb_pgchk_top.sv
module tb_pgchk_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  walk_status;
    logic [1:0]  acc_type;
    logic        user_mode, eff_user, eff_write, eff_noexec;
    logic [63:0] leaf;
    logic        wp_en, sup_exec_guard, sup_access_guard, long_mode;
    logic        nx_en, pae_en, ukey_en, skey_en;
    logic [31:0] ukey_rights, skey_rights;
    logic        out_valid, allow, wb_req;
    logic [2:0]  perm;
    logic [63:0] wb_entry;
    logic [5:0]  err_code;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pgchk_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .walk_status(walk_status),
        .acc_type(acc_type), .user_mode(user_mode), .eff_user(eff_user),
        .eff_write(eff_write), .eff_noexec(eff_noexec), .leaf(leaf),
        .wp_en(wp_en), .sup_exec_guard(sup_exec_guard),
        .sup_access_guard(sup_access_guard), .long_mode(long_mode),
        .nx_en(nx_en), .pae_en(pae_en), .ukey_en(ukey_en), .skey_en(skey_en),
        .ukey_rights(ukey_rights), .skey_rights(skey_rights),
        .out_valid(out_valid), .allow(allow), .perm(perm), .wb_req(wb_req),
        .wb_entry(wb_entry), .err_code(err_code)
    );

    // flags order: usr eu ew enx wp xg ag lm uke ske ld la
    typedef struct packed {
        logic [1:0]  acc;
        logic [11:0] fl;
        logic [3:0]  key;
        logic        e_allow;
        logic [2:0]  e_perm;
        logic        e_wb;
        logic [5:0]  e_err;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TABLE [NV] = '{
        {2'd0, 12'b0_0_1_0_1_0_0_1_1_1_0_0, 4'd0, 1'b1, 3'b101, 1'b1, 6'd0},  // R9 R10
        {2'd1, 12'b1_1_1_0_1_0_0_1_1_1_0_1, 4'd0, 1'b1, 3'b111, 1'b1, 6'd0},  // R9
        {2'd1, 12'b1_1_1_0_1_0_0_1_1_1_1_1, 4'd0, 1'b1, 3'b111, 1'b0, 6'd0},  // R9
        {2'd0, 12'b1_0_1_0_1_0_0_1_1_1_1_1, 4'd0, 1'b0, 3'b000, 1'b0, 6'd5},  // R2
        {2'd1, 12'b0_0_0_0_0_0_0_1_1_1_1_1, 4'd0, 1'b1, 3'b111, 1'b0, 6'd0},  // R4
        {2'd1, 12'b0_0_0_0_1_0_0_1_1_1_1_1, 4'd0, 1'b0, 3'b000, 1'b0, 6'd3},  // R4
        {2'd1, 12'b1_1_0_0_0_0_0_1_1_1_1_1, 4'd0, 1'b0, 3'b000, 1'b0, 6'd7},  // R4
        {2'd0, 12'b0_1_1_0_1_0_1_1_1_1_1_1, 4'd0, 1'b0, 3'b000, 1'b0, 6'd1},  // R3
        {2'd0, 12'b0_0_1_0_1_0_1_1_1_1_1_1, 4'd0, 1'b1, 3'b111, 1'b0, 6'd0},  // R3
        {2'd2, 12'b0_1_1_0_1_1_0_1_1_1_1_1, 4'd0, 1'b0, 3'b000, 1'b0, 6'd17}, // R5 R12
        {2'd2, 12'b1_1_1_0_1_1_0_1_1_1_1_1, 4'd0, 1'b1, 3'b111, 1'b0, 6'd0},  // R5
        {2'd2, 12'b0_0_1_1_1_0_0_1_1_1_1_1, 4'd0, 1'b0, 3'b000, 1'b0, 6'd17}, // R5
        {2'd0, 12'b1_1_1_0_1_0_0_1_1_1_1_1, 4'd1, 1'b0, 3'b000, 1'b0, 6'd37}, // R7 R8
        {2'd0, 12'b1_1_1_0_1_0_0_0_1_1_1_1, 4'd1, 1'b1, 3'b111, 1'b0, 6'd0},  // R6
        {2'd0, 12'b1_1_1_0_1_0_0_1_0_1_1_1, 4'd1, 1'b1, 3'b111, 1'b0, 6'd0},  // R6
        {2'd1, 12'b1_1_1_0_1_0_0_1_1_1_1_1, 4'd2, 1'b0, 3'b000, 1'b0, 6'd39}, // R7 R8
        {2'd0, 12'b1_1_1_0_1_0_0_1_1_1_1_1, 4'd2, 1'b1, 3'b101, 1'b0, 6'd0},  // R7
        {2'd1, 12'b0_0_1_0_0_0_0_1_1_1_1_1, 4'd4, 1'b1, 3'b111, 1'b0, 6'd0},  // R7
        {2'd1, 12'b0_0_1_0_1_0_0_1_1_1_1_1, 4'd4, 1'b0, 3'b000, 1'b0, 6'd35}, // R7 R8
        {2'd0, 12'b0_0_1_0_1_0_0_1_1_1_1_1, 4'd1, 1'b1, 3'b111, 1'b0, 6'd0},  // R6
        {2'd0, 12'b0_0_1_0_1_0_0_1_1_1_1_1, 4'd3, 1'b0, 3'b000, 1'b0, 6'd33}, // R6 R8
        {2'd2, 12'b1_1_1_0_1_0_0_1_1_1_1_1, 4'd1, 1'b1, 3'b100, 1'b0, 6'd0}   // R7
    };

    localparam logic [63:0] LEAF_BASE = 64'h0000_0000_1234_5001;

    function automatic logic [63:0] mk_leaf(input logic [3:0] k, input logic ld, input logic la);
        return LEAF_BASE | ({60'd0, k} << 59) | ({63'd0, ld} << 6) | ({63'd0, la} << 5);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; walk_status = 2'd0; acc_type = 2'd0;
        user_mode = 1'b0; eff_user = 1'b0; eff_write = 1'b0; eff_noexec = 1'b0;
        leaf = LEAF_BASE; wp_en = 1'b1; sup_exec_guard = 1'b0; sup_access_guard = 1'b0;
        long_mode = 1'b1; nx_en = 1'b1; pae_en = 1'b1; ukey_en = 1'b1; skey_en = 1'b1;
        ukey_rights = 32'h0000_0024; skey_rights = 32'h0000_0240;
    endtask

    // inputs already set; pulse strobe and sample one cycle later
    task automatic fire();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] lf;
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset allow", {63'd0, allow}, 64'd0);
        check("R1 reset err", {58'd0, err_code}, 64'd0);
        check("R1 reset entry", wb_entry, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TABLE[i];
            @(negedge clk);
            acc_type = v.acc;
            {user_mode, eff_user, eff_write, eff_noexec, wp_en, sup_exec_guard,
             sup_access_guard, long_mode, ukey_en, skey_en} = v.fl[11:2];
            lf = mk_leaf(v.key, v.fl[1], v.fl[0]);
            leaf = lf;
            fire();
            check($sformatf("R1 vec%0d valid", i), {63'd0, out_valid}, 64'd1);
            check($sformatf("R2-table vec%0d allow", i), {63'd0, allow}, {63'd0, v.e_allow});
            check($sformatf("R10 vec%0d perm", i), {61'd0, perm}, {61'd0, v.e_perm});
            check($sformatf("R9 vec%0d wb", i), {63'd0, wb_req}, {63'd0, v.e_wb});
            check($sformatf("R11 vec%0d err", i), {58'd0, err_code}, {58'd0, v.e_err});
            if (v.e_wb)
                check($sformatf("R9 vec%0d entry", i), wb_entry,
                      lf | 64'h20 | ((v.acc == 2'd1) ? 64'h40 : 64'h0));
            @(negedge clk);
            check($sformatf("R1 vec%0d drop", i), {63'd0, out_valid}, 64'd0);
        end

        // reserved-bit walk, user write: P W U RSVD = 15
        idle_inputs();
        @(negedge clk);
        walk_status = 2'd2; acc_type = 2'd1; user_mode = 1'b1; eff_user = 1'b1; eff_write = 1'b1;
        fire();
        check("R11 rsvd err", {58'd0, err_code}, 64'd15);
        check("R11 rsvd allow", {63'd0, allow}, 64'd0);

        // absent entry, user read: only U = 4
        idle_inputs();
        @(negedge clk);
        walk_status = 2'd1; user_mode = 1'b1; eff_user = 1'b1;
        fire();
        check("R11 absent err", {58'd0, err_code}, 64'd4);

        // supervisor fetch, absent, no-execute feature off, guard off: 0
        idle_inputs();
        @(negedge clk);
        walk_status = 2'd1; acc_type = 2'd2; nx_en = 1'b0;
        fire();
        check("R12 fetch tag off", {58'd0, err_code}, 64'd0);

        // same with execute guard on: fetch bit 16
        idle_inputs();
        @(negedge clk);
        walk_status = 2'd1; acc_type = 2'd2; nx_en = 1'b0; sup_exec_guard = 1'b1;
        fire();
        check("R12 fetch tag guard", {58'd0, err_code}, 64'd16);

        // absent with pae off, nx on: no fetch bit
        idle_inputs();
        @(negedge clk);
        walk_status = 2'd1; acc_type = 2'd2; pae_en = 1'b0;
        fire();
        check("R12 fetch tag pae off", {58'd0, err_code}, 64'd0);

        // no strobe: outputs hold, valid stays low
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        check("R1 no strobe", {63'd0, out_valid}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule